// File: doc/BRIEF.md
# XOR-combined hybrid branch direction predictor

This block predicts whether a conditional branch is taken. It holds two components. The global component keeps one outcome history register that every branch shares. It also keeps one table of 2-bit pattern counters that every branch shares, indexed by that history XORed with PC bits [11:2]. The local component keeps a table of 10-bit per-branch histories, selected by PC bits [11:2]. Each history directly indexes a table of 2-bit local counters. The taken/not-taken output is the XOR of the two counters' most significant bits. The output is combinational from the PC presented in the same cycle.

The local counter trains toward the actual outcome. The global counter trains toward the actual outcome XORed with the local component's prediction at update time. The global part therefore learns when the local guess must be inverted, and together the XOR output converges on the real outcome. Software-visible state is absent. The block is used by presenting a fetch PC on the predict port and, when the branch resolves, its PC, its outcome and the prediction that was issued on the update port. After reset, a sequential walk initialises every table entry, and `ready_o` stays low until the walk ends.

Top module: `xor_branch_pred`

## Requirements
- R1: While `rst_ni` is low, `ready_o` is low. After release, `ready_o` rises after exactly 2^max(IDX_W,HIST_W) rising edges, which is 1024 with the defaults, and then stays high. After the walk, every history reads zero and every counter reads 01 (weakly not taken), so every PC predicts not taken (0).
- R2: Updates presented while `ready_o` is low change no history and no counter.
- R3: `pred_o` equals bit 1 of the global counter at index (global history XOR PC[11:2]) XORed with bit 1 of the local counter at index (local history of entry PC[11:2]). It follows `pc_i` in the same cycle.
- R4: On an accepted update, the local counter selected by the branch's current local history moves one step toward the outcome (taken = up). It saturates at 00 and 11.
- R5: On an accepted update, the global counter at (global history XOR upd PC[11:2]) moves one step toward (outcome XOR local counter bit 1 read before the update). It saturates at 00 and 11. The global history shifts left with the outcome entering bit 0.
- R6: On an accepted update, the local history entry at upd PC[11:2] shifts left with the outcome entering bit 0.
- R7: A prediction for an entry that is being updated in the same cycle uses the values from before the update.
- R8: `mispredict_o` is high exactly when `ready_o`, `upd_valid_i` and (`upd_pred_i` != `upd_taken_i`) all hold. It is combinational.
- R9: For one branch repeating an 11-cycle pattern of ten taken followed by one not taken, every prediction is correct after warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ready_o | output | 1 | High once the initialisation walk is complete |
| pc_i | input | 32 | PC of the branch to predict |
| pred_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_pred_i | input | 1 | Prediction that was issued for this branch |
| mispredict_o | output | 1 | Issued prediction disagreed with the outcome |

## Verification
The hardest state to reach is a global counter driven by a non-trivial target. It moves only when the outcome differs from a local counter that is itself still training, and only for history values that recur. The stimulus reaches this state in two ways. It reuses a few PCs, so that local histories alias and counters saturate in both directions. It also runs a long periodic pattern on one branch, so that the global history cycles through a small set of indices. Updates issued during the initialisation walk check that nothing written early survives. Cycles in which the predicted and updated PC coincide expose any write-through.

// File: rtl/xbp_pkg.sv
package xbp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/xbp_walk.sv
module xbp_walk #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             clr_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o   <= '0;
      ready_o <= 1'b0;
    end else if (!ready_o) begin
      idx_o <= idx_o + 1'b1;
      if (idx_o == '1) ready_o <= 1'b1;
    end
  end

  assign clr_o = !ready_o;

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o); // R1
endmodule

// File: rtl/xbp_ctr_table.sv
module xbp_ctr_table
  import xbp_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [AW-1:0] clr_idx_i,
  input  logic [AW-1:0] rd_idx_i,
  output ctr_t          rd_ctr_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          wr_up_i,
  output ctr_t          wr_cur_o
);
  localparam int DEPTH = 1 << AW;

  ctr_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (clr_i)        mem[clr_idx_i] <= CTR_INIT;
    else if (wr_en_i) mem[wr_idx_i]  <= ctr_step(mem[wr_idx_i], wr_up_i);
  end

  assign rd_ctr_o = mem[rd_idx_i];
  assign wr_cur_o = mem[wr_idx_i];

  AST_CTR_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> ($past(wr_up_i) ? (mem[$past(wr_idx_i)] >= $past(wr_cur_o))
                                            : (mem[$past(wr_idx_i)] <= $past(wr_cur_o)))); // R4
endmodule

// File: rtl/xbp_hist_table.sv
module xbp_hist_table #(
  parameter int AW = 10,
  parameter int HW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [AW-1:0] clr_idx_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [HW-1:0] rd_hist_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic          wr_bit_i,
  output logic [HW-1:0] wr_cur_o
);
  localparam int DEPTH = 1 << AW;

  logic [HW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (clr_i)        mem[clr_idx_i] <= '0;
    else if (wr_en_i) mem[wr_idx_i]  <= {mem[wr_idx_i][HW-2:0], wr_bit_i};
  end

  assign rd_hist_o = mem[rd_idx_i];
  assign wr_cur_o  = mem[wr_idx_i];

  AST_HIST_AGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_i) |=> (mem[$past(wr_idx_i)][HW-1:1] == $past(wr_cur_o[HW-2:0]))); // R6
endmodule

// File: rtl/xor_branch_pred.sv
module xor_branch_pred
  import xbp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            ready_o,
  input  logic [PC_W-1:0] pc_i,
  output logic            pred_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_pred_i,
  output logic            mispredict_o
);
  localparam int WALK_W = (IDX_W > HIST_W) ? IDX_W : HIST_W;

  logic              clr;
  logic [WALK_W-1:0] walk_idx;
  logic              upd_en;
  logic [IDX_W-1:0]  ghr_q;
  logic [IDX_W-1:0]  prd_lidx, upd_lidx;
  logic [HIST_W-1:0] prd_hist, upd_hist;
  ctr_t              prd_lctr, upd_lctr, prd_gctr, upd_gctr;
  logic              unused_pc;

  assign prd_lidx  = pc_i[IDX_W+1:2];
  assign upd_lidx  = upd_pc_i[IDX_W+1:2];
  assign unused_pc = ^{pc_i[PC_W-1:IDX_W+2], pc_i[1:0],
                       upd_pc_i[PC_W-1:IDX_W+2], upd_pc_i[1:0], upd_gctr};
  assign upd_en    = ready_o && upd_valid_i;

  xbp_walk #(.CNT_W(WALK_W)) u_walk (
    .clk_i, .rst_ni, .clr_o(clr), .idx_o(walk_idx), .ready_o
  );

  xbp_hist_table #(.AW(IDX_W), .HW(HIST_W)) u_lhist (
    .clk_i, .rst_ni, .clr_i(clr), .clr_idx_i(walk_idx[IDX_W-1:0]),
    .rd_idx_i(prd_lidx), .rd_hist_o(prd_hist),
    .wr_en_i(upd_en), .wr_idx_i(upd_lidx), .wr_bit_i(upd_taken_i),
    .wr_cur_o(upd_hist)
  );

  xbp_ctr_table #(.AW(HIST_W)) u_lctr (
    .clk_i, .rst_ni, .clr_i(clr), .clr_idx_i(walk_idx[HIST_W-1:0]),
    .rd_idx_i(prd_hist), .rd_ctr_o(prd_lctr),
    .wr_en_i(upd_en), .wr_idx_i(upd_hist), .wr_up_i(upd_taken_i),
    .wr_cur_o(upd_lctr)
  );

  // global counter learns whether the local guess must be inverted
  xbp_ctr_table #(.AW(IDX_W)) u_gctr (
    .clk_i, .rst_ni, .clr_i(clr), .clr_idx_i(walk_idx[IDX_W-1:0]),
    .rd_idx_i(ghr_q ^ prd_lidx), .rd_ctr_o(prd_gctr),
    .wr_en_i(upd_en), .wr_idx_i(ghr_q ^ upd_lidx),
    .wr_up_i(upd_taken_i ^ upd_lctr[1]), .wr_cur_o(upd_gctr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ghr_q <= '0;
    else if (upd_en) ghr_q <= {ghr_q[IDX_W-2:0], upd_taken_i};
  end

  assign pred_o       = prd_gctr[1] ^ prd_lctr[1];
  assign mispredict_o = upd_en && (upd_pred_i != upd_taken_i);

  AST_GHR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ready_o && upd_valid_i) |=> $stable(ghr_q)); // R2
  AST_GHR_NEWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && upd_valid_i) |=> (ghr_q[0] == $past(upd_taken_i))); // R5
  AST_MISS_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> (ready_o && upd_valid_i)); // R8
  AST_NO_PRED_TAKEN_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> !pred_o); // R1
endmodule

// File: tb/xor_branch_pred_bench.sv
`timescale 1ns/1ps
module xor_branch_pred_bench;
  localparam int NENT = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ready_o, pred_o, mispredict_o;
  logic [31:0] pc_i = '0, upd_pc_i = '0;
  logic        upd_valid_i = 1'b0, upd_taken_i = 1'b0, upd_pred_i = 1'b0;

  int n_cmp = 0, n_bad = 0;
  int lh [NENT];
  int lc [NENT];
  int gc [NENT];
  int ghr, walk_cnt;
  bit m_ready;

  always #2.5 clk_i = ~clk_i;

  xor_branch_pred u_xor_branch_pred (.*);

  function automatic int stepf(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int lidx(logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  function automatic bit model_pred(logic [31:0] pc);
    int li = lidx(pc);
    bit l = lc[lh[li]] >= 2;
    bit g = gc[(ghr ^ li) & (NENT-1)] >= 2;
    return l ^ g;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NENT; i++) begin lh[i] = 0; lc[i] = 1; gc[i] = 1; end
    ghr = 0; walk_cnt = 0; m_ready = 0;
  endtask

  // called at a negedge; leaves at the next negedge
  task automatic step(input logic [31:0] pc, input bit v, input logic [31:0] upc,
                      input bit tk, input bit up, input bit fb, input string tag,
                      output bit exp_p);
    pc_i = pc; upd_valid_i = v; upd_pc_i = upc; upd_taken_i = tk; upd_pred_i = up;
    #0.5;
    exp_p = model_pred(pc);
    if (fb) upd_pred_i = pred_o;
    #0.5;
    check(tag, pred_o, exp_p);
    check("R1 ready", ready_o, m_ready);
    check("R8", mispredict_o, m_ready && v && (upd_pred_i != tk));
    @(posedge clk_i);
    if (m_ready && v) begin
      int li = lidx(upc);
      int h = lh[li];
      bit lp = lc[h] >= 2;
      int gi = (ghr ^ li) & (NENT-1);
      lc[h]  = stepf(lc[h], tk);
      gc[gi] = stepf(gc[gi], tk ^ lp);
      lh[li] = ((h << 1) | int'(tk)) & (NENT-1);
      ghr    = ((ghr << 1) | int'(tk)) & (NENT-1);
    end
    if (!m_ready) begin
      walk_cnt++;
      if (walk_cnt == NENT) m_ready = 1;
    end
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    bit p;
    int errs;
    model_reset();
    repeat (3) @(negedge clk_i);
    check("R1 reset", ready_o, 1'b0);
    rst_ni = 1'b1;
    // R2: updates during the walk must be dropped
    for (int i = 0; i < NENT; i++)
      step($urandom & 32'h3c, 1'b1, $urandom & 32'h3c, 1'($urandom), 1'($urandom), 0, "R2", p);
    check("R1 walk done", ready_o, 1'b1);
    for (int i = 0; i < 64; i++)
      step(32'(i*4), 1'b0, '0, 1'b0, 1'b0, 0, "R1 init pred", p);
    // R3 R4 R5 R6: aliased random traffic
    for (int i = 0; i < 800; i++)
      step($urandom & 32'h1c, 1'b1, $urandom & 32'h1c, 1'($urandom), 1'($urandom), 0, "R3 R4 R5 R6", p);
    // R4 saturation both ways
    for (int i = 0; i < 30; i++) step(32'h200, 1'b1, 32'h200, 1'b1, 1'b0, 0, "R4 up", p);
    for (int i = 0; i < 30; i++) step(32'h200, 1'b1, 32'h200, 1'b0, 1'b1, 0, "R4 down", p);
    // R7: predict the entry that is being written
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a = $urandom & 32'h0c;
      step(a, 1'b1, a, 1'($urandom), 1'($urandom), 0, "R7", p);
    end
    // R9: ten taken then one not taken, one branch, prediction fed back
    errs = 0;
    for (int i = 0; i < 700; i++) begin
      bit tk = (i % 11) != 10;
      step(32'h400, 1'b1, 32'h400, tk, 1'b0, 1, "R9 model", p);
      if (i >= 500 && p != tk) errs++;
    end
    check("R9 learned", 1'(errs == 0), 1'b1);
    summary();
    $finish;
  end
endmodule